// File: doc/BRIEF.md
# Oversampled Serial Receiver with Flushing Word Queue

This block turns an asynchronous serial line into stored words. It runs from the system clock and takes a one-cycle tick at sixteen times the bit rate. The line passes through a two-stage synchroniser. On a tick, a falling level marks a possible start bit. Each bit cell, including the start and stop cells, is resolved by a two-of-three vote over its 7th, 8th and 9th tick samples. A start cell that votes high counts as noise, and the receiver goes back to waiting.

Each completed word is stored in a small queue, together with its optional parity bit. The word has seven or eight data bits, sent least significant bit first. If a word arrives while the queue is full, the queue empties completely. A low stop bit raises a sticky framing flag. While the shutdown input is high the receiver stays idle, and any edge on the line instead sets a sticky activity flag. A host reads the head of the queue and advances it with a pop strobe. A clear strobe empties the queue and drops both flags.

Top module: `rxm_receiver`

## Requirements
- R1: After reset, avail_o, frame_err_o and activity_o are 0 and both head outputs are 0.
- R2: A start is taken only when a tick sees the synchronised line low after it was high on the previous tick. If the vote of that start cell is high, nothing is stored and the receiver waits for the next falling edge.
- R3: Each bit cell is decided by a majority of its 7th, 8th and 9th tick samples, counting the start-detect tick as the 1st. One wrong sample among those three does not change the stored value.
- R4: With len7_i=0, eight data bits follow the start bit, least significant first, and appear on head_data_o[7:0].
- R5: With len7_i=1, seven data bits are received and head_data_o[7] reads 0.
- R6: With par_en_i=1, one more bit follows the data and appears on head_par_o. With par_en_i=0, head_par_o is 0.
- R7: Words leave the queue in arrival order, and up to DEPTH (8) words are held. A pop_i pulse drops the head. A pop on an empty queue has no effect.
- R8: A word that completes while the queue is full, with no pop in the same cycle, empties the whole queue. The next word then becomes the only entry.
- R9: A stop cell that votes low sets frame_err_o. The word is still stored. The flag holds until a pop_i or clr_i pulse.
- R10: While shutdown_i=1, no word is received. Any edge on the synchronised line sets activity_o, which holds until a pop_i or clr_i pulse. With shutdown_i=0, line activity leaves activity_o at 0.
- R11: A clr_i pulse empties the queue and clears frame_err_o and activity_o.
- R12: While avail_o is 0, head_data_o and head_par_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| len7_i | input | 1 | 1 selects seven data bits, 0 selects eight |
| par_en_i | input | 1 | 1 receives and stores a parity bit |
| shutdown_i | input | 1 | 1 stops reception and enables activity detection |
| clr_i | input | 1 | Empties the queue and clears both flags |
| pop_i | input | 1 | Drops the head word |
| head_data_o | output | DMAX (8) | Oldest stored data bits |
| head_par_o | output | 1 | Parity bit stored with the head word |
| avail_o | output | 1 | Queue holds at least one word |
| frame_err_o | output | 1 | Sticky framing-error flag |
| activity_o | output | 1 | Sticky line-activity flag in shutdown |

## Verification
The bench builds the block with its defaults: 16 ticks per bit, an 8-entry queue and up to eight data bits. It supplies a tick every fourth clock, so a full frame takes a few hundred cycles. This makes the overflow flush reachable within a short run: eight stored words followed by a ninth. The tick spacing is wider than the synchroniser delay, so the bench can place a single wrong sample exactly on the 8th sample of a cell. It also holds a short low pulse that stops before the vote window.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rxm_sync.sv
module rxm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rxm_deframer.sv
module rxm_deframer import rxm_pkg::*; #(
  parameter int OVS  = 16,
  parameter int DMAX = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          rx_s_i,
  input  logic          shdn_i,
  input  logic          len7_i,
  input  logic          par_en_i,
  output logic          push_o,
  output logic [DMAX:0] word_o,
  output logic          ferr_set_o
);
  localparam int SW  = DMAX + 1;
  localparam int CW  = $clog2(OVS);
  localparam int NW  = $clog2(SW + 1);
  localparam int S_A = OVS/2 - 2;
  localparam int S_B = OVS/2 - 1;
  localparam int S_C = OVS/2;

  rx_state_e     state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [NW-1:0] bitn_q, bitn_n;
  logic [SW-1:0] sr_q, sr_n;
  logic          smp_a_q, smp_a_n, smp_b_q, smp_b_n;
  logic          prev_q, prev_n;
  logic          vote;
  logic [NW-1:0] nbits, dbits;
  logic [SW-1:0] aligned;

  assign nbits   = NW'(DMAX) - NW'(len7_i) + NW'(par_en_i);
  assign dbits   = NW'(DMAX) - NW'(len7_i);
  assign vote    = vote3(smp_a_q, smp_b_q, rx_s_i);
  assign aligned = sr_q >> (NW'(SW) - nbits);

  always_comb begin
    for (int i = 0; i < DMAX; i++)
      word_o[i] = (NW'(i) < dbits) ? aligned[i] : 1'b0;
    word_o[DMAX] = par_en_i & sr_q[SW-1];
  end

  always_comb begin
    state_n    = state_q;
    cnt_n      = cnt_q;
    bitn_n     = bitn_q;
    sr_n       = sr_q;
    smp_a_n    = smp_a_q;
    smp_b_n    = smp_b_q;
    prev_n     = prev_q;
    push_o     = 1'b0;
    ferr_set_o = 1'b0;
    if (shdn_i) begin
      state_n = ST_IDLE;
      if (tick_i) prev_n = rx_s_i;
    end else if (tick_i) begin
      if (state_q == ST_IDLE) begin
        prev_n = rx_s_i;
        if (prev_q && !rx_s_i) begin
          state_n = ST_START;
          cnt_n   = CW'(1);
          bitn_n  = '0;
        end
      end else begin
        cnt_n = cnt_q + CW'(1);
        if (cnt_q == CW'(S_A)) smp_a_n = rx_s_i;
        if (cnt_q == CW'(S_B)) smp_b_n = rx_s_i;
        if (cnt_q == CW'(S_C)) begin
          case (state_q)
            ST_START: if (vote) begin
              state_n = ST_IDLE;
              prev_n  = 1'b1;
            end
            ST_DATA: begin
              sr_n   = {vote, sr_q[SW-1:1]};
              bitn_n = bitn_q + NW'(1);
            end
            ST_STOP: begin
              push_o     = 1'b1;
              ferr_set_o = !vote;
              state_n    = ST_IDLE;
              prev_n     = vote;
            end
            default: ;
          endcase
        end
        if (cnt_q == CW'(OVS-1)) begin
          cnt_n = '0;
          if (state_q == ST_START) state_n = ST_DATA;
          else if (state_q == ST_DATA && bitn_q == nbits) state_n = ST_STOP;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
      sr_q    <= '0;
      smp_a_q <= 1'b1;
      smp_b_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      bitn_q  <= bitn_n;
      sr_q    <= sr_n;
      smp_a_q <= smp_a_n;
      smp_b_q <= smp_b_n;
      prev_q  <= prev_n;
    end
  end
endmodule

// File: rtl/rxm_fifo.sv
module rxm_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       push_i,
  input  logic [W-1:0]               data_i,
  input  logic                       pop_i,
  output logic [W-1:0]               head_o,
  output logic                       avail_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [LW-1:0] lvl_q, lvl_n;
  logic          full, empty, do_pop, do_push, flush;

  always_comb begin
    full    = (lvl_q == LW'(DEPTH));
    empty   = (lvl_q == '0);
    do_pop  = pop_i && !empty;
    flush   = clr_i || (push_i && full && !do_pop);
    do_push = push_i && !flush;
    wr_n    = wr_q;
    rd_n    = rd_q;
    lvl_n   = lvl_q;
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      lvl_n = '0;
    end else begin
      if (do_push) wr_n = wr_q + AW'(1);
      if (do_pop)  rd_n = rd_q + AW'(1);
      lvl_n = lvl_q + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      lvl_q <= lvl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= data_i;
  end

  assign head_o  = empty ? '0 : mem[rd_q];
  assign avail_o = !empty;
  assign level_o = lvl_q;
endmodule

// File: rtl/rxm_receiver.sv
module rxm_receiver #(
  parameter int OVS   = 16,
  parameter int DMAX  = 8,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_i,
  input  logic            tick_i,
  input  logic            len7_i,
  input  logic            par_en_i,
  input  logic            shutdown_i,
  input  logic            clr_i,
  input  logic            pop_i,
  output logic [DMAX-1:0] head_data_o,
  output logic            head_par_o,
  output logic            avail_o,
  output logic            frame_err_o,
  output logic            activity_o
);
  localparam int LW = $clog2(DEPTH + 1);

  logic          rx_s, rx_d_q;
  logic          push, ferr_set;
  logic [DMAX:0] word, head;
  logic [LW-1:0] level;
  logic          ferr_q, ferr_n, act_q, act_n;

  rxm_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
  );

  rxm_deframer #(.OVS(OVS), .DMAX(DMAX)) u_deframer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_s_i(rx_s),
    .shdn_i(shutdown_i), .len7_i(len7_i), .par_en_i(par_en_i),
    .push_o(push), .word_o(word), .ferr_set_o(ferr_set)
  );

  rxm_fifo #(.W(DMAX+1), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .push_i(push), .data_i(word),
    .pop_i(pop_i), .head_o(head), .avail_o(avail_o), .level_o(level)
  );

  always_comb begin
    ferr_n = ferr_q;
    act_n  = act_q;
    if (clr_i || pop_i) begin
      ferr_n = 1'b0;
      act_n  = 1'b0;
    end
    if (ferr_set) ferr_n = 1'b1;
    if (shutdown_i && (rx_s != rx_d_q)) act_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_d_q <= 1'b1;
      ferr_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      rx_d_q <= rx_s;
      ferr_q <= ferr_n;
      act_q  <= act_n;
    end
  end

  assign head_data_o = head[DMAX-1:0];
  assign head_par_o  = head[DMAX];
  assign frame_err_o = ferr_q;
  assign activity_o  = act_q;
endmodule

// File: rtl/rxm_checker.sv
module rxm_checker #(
  parameter int DMAX  = 8,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       pop_i,
  input logic                       clr_i,
  input logic                       shutdown_i,
  input logic                       push,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic                       avail_o,
  input logic [DMAX-1:0]            head_data_o,
  input logic                       head_par_o,
  input logic                       frame_err_o
);
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !avail_o); // R11
  AST_OVERFLOW_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (push && level == ($clog2(DEPTH+1))'(DEPTH) && !pop_i) |=> !avail_o); // R8
  AST_EMPTY_HEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !avail_o |-> (head_data_o == '0 && !head_par_o)); // R12
  AST_SHDN_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_i && $past(shutdown_i)) |-> !push); // R10
  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err_o && !pop_i && !clr_i) |=> frame_err_o); // R9
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ($clog2(DEPTH+1))'(DEPTH)); // R7
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!avail_o && !push) |=> !avail_o); // R7
endmodule

bind rxm_receiver rxm_checker #(.DMAX(DMAX), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pop_i(pop_i), .clr_i(clr_i),
  .shutdown_i(shutdown_i), .push(push), .level(level), .avail_o(avail_o),
  .head_data_o(head_data_o), .head_par_o(head_par_o),
  .frame_err_o(frame_err_o)
);

// File: tb/sim_rxm_receiver.sv
`timescale 1ns/1ps
module sim_rxm_receiver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1, tick = 1'b0, len7 = 1'b0, par_en = 1'b0;
  logic       shdn = 1'b0, clr = 1'b0, pop = 1'b0;
  logic [7:0] hdata;
  logic       hpar, avail, ferr, act;
  int         n_chk = 0, n_fail = 0;
  logic [1:0] tcnt = 2'd0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= tcnt + 2'd1;
    tick <= (tcnt == 2'd3);
  end

  rxm_receiver u0 (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .len7_i(len7),
    .par_en_i(par_en), .shutdown_i(shdn), .clr_i(clr), .pop_i(pop),
    .head_data_o(hdata), .head_par_o(hpar), .avail_o(avail),
    .frame_err_o(ferr), .activity_o(act)
  );

  task automatic chk(input bit ok, input string tag, input int actual, input int expct);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expct);
    end
  endtask

  task automatic next_tick();
    do @(posedge clk); while (tick !== 1'b1);
    #1;
  endtask

  task automatic idle_ticks(input int n);
    rx = 1'b1;
    for (int i = 0; i < n; i++) next_tick();
  endtask

  // cell 0 = start, cells 1..n = bits LSB first, cell n+1 = stop
  task automatic send_frame(input logic [8:0] bits, input int n, input logic stop, input int gcell);
    for (int c = 0; c <= n + 1; c++) begin
      logic v;
      v = (c == 0) ? 1'b0 : (c == n + 1) ? stop : bits[c-1];
      for (int j = 0; j < 16; j++) begin
        rx = (c == gcell && j == 7) ? ~v : v;
        next_tick();
      end
    end
    idle_ticks(4);
    @(negedge clk);
  endtask

  task automatic do_pop();
    @(negedge clk) pop = 1'b1;
    @(negedge clk) pop = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!avail && !ferr && !act, "R1 flags after reset", {avail, ferr, act}, 0);
    chk(hdata == 8'h00 && !hpar, "R1 R12 head after reset", {hpar, hdata}, 0);
  endtask

  task automatic t_basic8();
    len7 = 1'b0; par_en = 1'b0;
    send_frame(9'h0A5, 8, 1'b1, -1);
    chk(avail, "R4 word stored", avail, 1);
    chk(hdata == 8'hA5, "R4 eight bit data", hdata, 8'hA5);
    chk(!hpar, "R6 parity off reads 0", hpar, 0);
    chk(!act, "R10 no activity outside shutdown", act, 0);
    do_pop();
    chk(!avail, "R7 pop empties", avail, 0);
  endtask

  task automatic t_seven_par();
    len7 = 1'b1; par_en = 1'b1;
    send_frame(9'h0B5, 8, 1'b1, -1); // 7 data bits 0x35, then parity 1
    chk(hdata == 8'h35, "R5 seven bit data", hdata, 8'h35);
    chk(hpar, "R6 parity stored", hpar, 1);
    do_pop();
    len7 = 1'b0; par_en = 1'b0;
  endtask

  task automatic t_majority();
    send_frame(9'h03C, 8, 1'b1, 3); // wrong 8th sample on data bit 2
    chk(hdata == 8'h3C, "R3 one bad sample in data cell", hdata, 8'h3C);
    do_pop();
    send_frame(9'h0C3, 8, 1'b1, 0); // wrong 8th sample on start cell
    chk(avail && hdata == 8'hC3, "R3 one bad sample in start cell", hdata, 8'hC3);
    do_pop();
  endtask

  task automatic t_glitch();
    rx = 1'b0;
    for (int j = 0; j < 5; j++) next_tick();
    idle_ticks(200);
    @(negedge clk);
    chk(!avail, "R2 short low pulse rejected", avail, 0);
    chk(!ferr, "R2 no framing flag from glitch", ferr, 0);
  endtask

  task automatic t_order();
    par_en = 1'b1;
    send_frame(9'h111, 9, 1'b1, -1);
    send_frame(9'h022, 9, 1'b1, -1);
    send_frame(9'h133, 9, 1'b1, -1);
    chk(hdata == 8'h11 && hpar, "R7 first out", {hpar, hdata}, 9'h111);
    do_pop();
    chk(hdata == 8'h22 && !hpar, "R7 second out", {hpar, hdata}, 9'h022);
    do_pop();
    chk(hdata == 8'h33 && hpar, "R7 third out", {hpar, hdata}, 9'h133);
    do_pop();
    do_pop();
    chk(!avail && hdata == 8'h00, "R7 R12 pop on empty ignored", {avail, hdata}, 0);
    par_en = 1'b0;
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 8; i++) send_frame(9'(8'h40 + i), 8, 1'b1, -1);
    chk(avail && hdata == 8'h40, "R7 eight words held", hdata, 8'h40);
    send_frame(9'h0EE, 8, 1'b1, -1);
    chk(!avail, "R8 ninth word flushes queue", avail, 0);
    send_frame(9'h077, 8, 1'b1, -1);
    chk(avail && hdata == 8'h77, "R8 next word alone after flush", hdata, 8'h77);
    do_pop();
    chk(!avail, "R8 only one entry after flush", avail, 0);
  endtask

  task automatic t_frame_err();
    send_frame(9'h05A, 8, 1'b0, -1);
    chk(ferr, "R9 low stop sets flag", ferr, 1);
    chk(avail && hdata == 8'h5A, "R9 word still stored", hdata, 8'h5A);
    idle_ticks(40);
    @(negedge clk);
    chk(ferr, "R9 flag holds", ferr, 1);
    do_pop();
    chk(!ferr, "R9 pop clears flag", ferr, 0);
  endtask

  task automatic t_shutdown();
    @(negedge clk) shdn = 1'b1;
    rx = 1'b0;
    for (int j = 0; j < 200; j++) next_tick();
    idle_ticks(10);
    @(negedge clk);
    chk(act, "R10 edge in shutdown sets activity", act, 1);
    chk(!avail, "R10 nothing received in shutdown", avail, 0);
    shdn = 1'b0;
    idle_ticks(10);
    @(negedge clk);
    chk(act, "R10 activity holds", act, 1);
    do_clr();
    chk(!act, "R11 clear drops activity", act, 0);
  endtask

  task automatic t_clear();
    send_frame(9'h0A1, 8, 1'b1, -1);
    send_frame(9'h0B2, 8, 1'b0, -1);
    chk(avail && ferr, "R11 setup two words and flag", {avail, ferr}, 3);
    do_clr();
    chk(!avail && !ferr, "R11 clear empties and drops flag", {avail, ferr}, 0);
    chk(hdata == 8'h00 && !hpar, "R12 head zero after clear", {hpar, hdata}, 0);
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    idle_ticks(4);
    t_basic8();
    t_seven_par();
    t_majority();
    t_glitch();
    t_order();
    t_overflow();
    t_frame_err();
    t_shutdown();
    t_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule